// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Selector

This block sits between the interrupt state of a multi-processor interrupt controller and the request lines of the processors it serves. For every processor it looks at all interrupts that are both enabled and pending for that processor, picks the most urgent one, and then applies two gates. The winner's ID is published only if its priority passes the processor's priority mask. The request line is raised only if that published winner would also pre-empt what the processor is already running.

Lower numeric priority means more urgent. Interrupts 0 to 31 carry a separate 8-bit priority for each processor, while higher-numbered interrupts share one priority for all processors. The ID 1023 means "nothing to take". The running priority is 9 bits wide so that 0x100 can stand for an idle processor, less urgent than any real priority. The search is combinational and the results are registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `prio_sel`

## Requirements
- R1: While reset is asserted, and after it, until the first active clock edge, every published ID is 1023 and every request line is low.
- R2: Only an interrupt whose enable bit and pending bit are both set for a given processor can win for that processor. The bit for interrupt i and processor c sits at index i*NUM_CPU+c of both vectors. A published ID is always either 1023 or below NUM_IRQ.
- R3: Among candidates, the one with the numerically lowest priority wins.
- R4: On equal priority, the lowest interrupt number wins.
- R5: The winner is published only when its priority is less than or equal to that processor's 8-bit mask. Otherwise the ID is 1023 and the request is low.
- R6: The request line is high only when the published winner's priority is strictly less than the processor's 9-bit running priority. An equal running priority publishes the ID but keeps the request low.
- R7: When the global enable or the processor's own interface enable is low, that processor's ID is 1023 and its request is low. Other processors are not affected.
- R8: For interrupts 0 to 31, processor c uses the byte at bits (i*NUM_CPU+c)*8 of the banked priority vector. For interrupt i of 32 and up, every processor uses the byte at bits (i-32)*8 of the shared priority vector.
- R9: Outputs are registered: a change of inputs shows on the outputs after the next rising clock edge, and not before.
- R10: With no enabled and pending candidate, the ID is 1023 and the request is low, even when the running priority is idle (0x100).
- R11: Enable and pending bits of one processor have no effect on the outputs of another processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| globalEn | input | 1 | Global distribution enable |
| cpuEn | input | NUM_CPU | Per-processor interface enable |
| enBits | input | NUM_IRQ*NUM_CPU | Enable bit per interrupt and processor |
| pendBits | input | NUM_IRQ*NUM_CPU | Pending bit per interrupt and processor |
| bankPrio | input | 32*NUM_CPU*8 | Per-processor priorities of interrupts 0 to 31 |
| sharedPrio | input | (NUM_IRQ-32)*8 | Shared priorities of interrupts 32 and up |
| prioMask | input | NUM_CPU*8 | Per-processor priority mask |
| runPrio | input | NUM_CPU*9 | Per-processor running priority, 0x100 = idle |
| pendId | output | NUM_CPU*10 | Per-processor published highest-pending ID, 1023 = none |
| irqReq | output | NUM_CPU | Per-processor interrupt request line |

## Verification
The bench builds the block with 64 interrupts and 2 processors. Sixty-four interrupts put candidates in both the banked range and the shared range at once, so ties and priority contests can cross the boundary at 32. Two processors are enough to show that the per-processor enable, pending, priority, mask and running-priority inputs stay independent, and that one interface enable silences only its own processor.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;
  localparam int ID_W = 10;
  localparam int PRIO_W = 8;
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;
  localparam logic [PRIO_W:0] IDLE_PRIO = 9'h100;

  // Strobes from control to datapath, one per processor.
  typedef struct packed {
    logic gateOpen;
  } ctrl_t;
endpackage

// File: rtl/prio_sel_ctrl.sv
module prio_sel_ctrl
  import prio_sel_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                      globalEn,
  input  logic [NUM_CPU-1:0]        cpuEn,
  output ctrl_t [NUM_CPU-1:0]       strb
);
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      strb[c].gateOpen = globalEn & cpuEn[c];
    end
  end
endmodule

// File: rtl/prio_sel_search.sv
module prio_sel_search
  import prio_sel_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 4,
  parameter int CPU_IDX = 0
) (
  input  logic [NUM_IRQ*NUM_CPU-1:0]     enBits,
  input  logic [NUM_IRQ*NUM_CPU-1:0]     pendBits,
  input  logic [32*NUM_CPU*PRIO_W-1:0]   bankPrio,
  input  logic [(NUM_IRQ-32)*PRIO_W-1:0] sharedPrio,
  output logic [PRIO_W:0]                bestPrio,
  output logic [ID_W-1:0]                bestId
);
  always_comb begin
    bestPrio = IDLE_PRIO;
    bestId   = NO_IRQ;
    // Banked range first; ascending scan with strict compare keeps the lowest ID on ties.
    for (int i = 0; i < 32; i++) begin
      if (enBits[i*NUM_CPU+CPU_IDX] && pendBits[i*NUM_CPU+CPU_IDX] &&
          ({1'b0, bankPrio[(i*NUM_CPU+CPU_IDX)*PRIO_W +: PRIO_W]} < bestPrio)) begin
        bestPrio = {1'b0, bankPrio[(i*NUM_CPU+CPU_IDX)*PRIO_W +: PRIO_W]};
        bestId   = ID_W'(i);
      end
    end
    for (int i = 32; i < NUM_IRQ; i++) begin
      if (enBits[i*NUM_CPU+CPU_IDX] && pendBits[i*NUM_CPU+CPU_IDX] &&
          ({1'b0, sharedPrio[(i-32)*PRIO_W +: PRIO_W]} < bestPrio)) begin
        bestPrio = {1'b0, sharedPrio[(i-32)*PRIO_W +: PRIO_W]};
        bestId   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_sel_dp.sv
module prio_sel_dp
  import prio_sel_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  ctrl_t [NUM_CPU-1:0]            strb,
  input  logic [NUM_IRQ*NUM_CPU-1:0]     enBits,
  input  logic [NUM_IRQ*NUM_CPU-1:0]     pendBits,
  input  logic [32*NUM_CPU*PRIO_W-1:0]   bankPrio,
  input  logic [(NUM_IRQ-32)*PRIO_W-1:0] sharedPrio,
  input  logic [NUM_CPU*PRIO_W-1:0]      prioMask,
  input  logic [NUM_CPU*(PRIO_W+1)-1:0]  runPrio,
  output logic [NUM_CPU*ID_W-1:0]        pendId,
  output logic [NUM_CPU-1:0]             irqReq
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [PRIO_W:0]   bestPrio;
    logic [ID_W-1:0]   bestId;
    logic [ID_W-1:0]   nextId;
    logic              nextReq;

    prio_sel_search #(
      .NUM_IRQ(NUM_IRQ),
      .NUM_CPU(NUM_CPU),
      .CPU_IDX(c)
    ) u_search (
      .enBits    (enBits),
      .pendBits  (pendBits),
      .bankPrio  (bankPrio),
      .sharedPrio(sharedPrio),
      .bestPrio  (bestPrio),
      .bestId    (bestId)
    );

    always_comb begin
      nextId  = NO_IRQ;
      nextReq = 1'b0;
      if (strb[c].gateOpen && (bestPrio <= {1'b0, prioMask[c*PRIO_W +: PRIO_W]})) begin
        nextId  = bestId;
        nextReq = bestPrio < runPrio[c*(PRIO_W+1) +: (PRIO_W+1)];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pendId[c*ID_W +: ID_W] <= NO_IRQ;
        irqReq[c]              <= 1'b0;
      end else begin
        pendId[c*ID_W +: ID_W] <= nextId;
        irqReq[c]              <= nextReq;
      end
    end
  end
endmodule

// File: rtl/prio_sel.sv
module prio_sel
  import prio_sel_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           globalEn,
  input  logic [NUM_CPU-1:0]             cpuEn,
  input  logic [NUM_IRQ*NUM_CPU-1:0]     enBits,
  input  logic [NUM_IRQ*NUM_CPU-1:0]     pendBits,
  input  logic [32*NUM_CPU*8-1:0]        bankPrio,
  input  logic [(NUM_IRQ-32)*8-1:0]      sharedPrio,
  input  logic [NUM_CPU*8-1:0]           prioMask,
  input  logic [NUM_CPU*9-1:0]           runPrio,
  output logic [NUM_CPU*10-1:0]          pendId,
  output logic [NUM_CPU-1:0]             irqReq
);
  ctrl_t [NUM_CPU-1:0] strb;

  prio_sel_ctrl #(.NUM_CPU(NUM_CPU)) u_ctrl (
    .globalEn(globalEn),
    .cpuEn   (cpuEn),
    .strb    (strb)
  );

  prio_sel_dp #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .enBits    (enBits),
    .pendBits  (pendBits),
    .bankPrio  (bankPrio),
    .sharedPrio(sharedPrio),
    .prioMask  (prioMask),
    .runPrio   (runPrio),
    .pendId    (pendId),
    .irqReq    (irqReq)
  );
endmodule

// File: rtl/prio_sel_chk.sv
module prio_sel_chk
  import prio_sel_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       globalEn,
  input logic [NUM_CPU-1:0]         cpuEn,
  input logic [NUM_IRQ*NUM_CPU-1:0] enBits,
  input logic [NUM_IRQ*NUM_CPU-1:0] pendBits,
  input logic [NUM_CPU*9-1:0]       runPrio,
  input logic [NUM_CPU*10-1:0]      pendId,
  input logic [NUM_CPU-1:0]         irqReq
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    logic anyCand;
    logic [ID_W-1:0] idNow;
    assign idNow = pendId[c*ID_W +: ID_W];

    always_comb begin
      anyCand = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        anyCand = anyCand | (enBits[i*NUM_CPU+c] & pendBits[i*NUM_CPU+c]);
      end
    end

    AST_REQ_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      irqReq[c] |-> (idNow != NO_IRQ)); // R6
    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      irqReq[c] |-> ($past(runPrio[c*9 +: 9]) != 9'd0)); // R6
    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(globalEn) && $past(cpuEn[c])) |-> (idNow == NO_IRQ && !irqReq[c])); // R7
    AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (idNow == NO_IRQ) || (idNow < ID_W'(NUM_IRQ))); // R2
    AST_NO_CAND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(anyCand) |-> (idNow == NO_IRQ && !irqReq[c])); // R10
  end
endmodule

bind prio_sel prio_sel_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .globalEn(globalEn),
  .cpuEn   (cpuEn),
  .enBits  (enBits),
  .pendBits(pendBits),
  .runPrio (runPrio),
  .pendId  (pendId),
  .irqReq  (irqReq)
);

// File: tb/tb_prio_sel.sv
module tb_prio_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 64;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic globalEn;
  logic [NC-1:0] cpuEn;
  logic [NI*NC-1:0] enBits, pendBits;
  logic [32*NC*8-1:0] bankPrio;
  logic [(NI-32)*8-1:0] sharedPrio;
  logic [NC*8-1:0] prioMask;
  logic [NC*9-1:0] runPrio;
  logic [NC*10-1:0] pendId;
  logic [NC-1:0] irqReq;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_sel #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut (
    .clk(clk), .rst_n(rst_n), .globalEn(globalEn), .cpuEn(cpuEn),
    .enBits(enBits), .pendBits(pendBits), .bankPrio(bankPrio),
    .sharedPrio(sharedPrio), .prioMask(prioMask), .runPrio(runPrio),
    .pendId(pendId), .irqReq(irqReq)
  );

  function automatic int idOf(int c);
    return int'(pendId[c*10 +: 10]);
  endfunction

  task automatic check(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearAll();
    enBits = '0; pendBits = '0;
    for (int k = 0; k < 32*NC; k++) bankPrio[k*8 +: 8] = 8'hA0;
    for (int k = 0; k < NI-32; k++) sharedPrio[k*8 +: 8] = 8'hA0;
    for (int c = 0; c < NC; c++) begin
      prioMask[c*8 +: 8] = 8'hF0;
      runPrio[c*9 +: 9]  = 9'h100;
    end
    globalEn = 1'b1; cpuEn = '1;
  endtask

  task automatic setCand(int irq, int c);
    enBits[irq*NC+c] = 1'b1; pendBits[irq*NC+c] = 1'b1;
  endtask

  task automatic setPrio(int irq, int c, logic [7:0] p);
    if (irq < 32) bankPrio[(irq*NC+c)*8 +: 8] = p;
    else sharedPrio[(irq-32)*8 +: 8] = p;
  endtask

  task automatic t_reset();
    clearAll(); setCand(40, 0); setCand(3, 1);
    step(); step();
    check("R1 id cpu0 in reset", idOf(0), 1023);
    check("R1 id cpu1 in reset", idOf(1), 1023);
    check("R1 req in reset", int'(irqReq), 0);
  endtask

  task automatic t_candidates();
    clearAll(); step();
    check("R10 no cand id", idOf(0), 1023);
    check("R10 no cand req idle run", int'(irqReq[0]), 0);
    enBits[40*NC+0] = 1'b1; pendBits[41*NC+0] = 1'b1; step();
    check("R2 enable-only / pending-only ignored", idOf(0), 1023);
    setCand(42, 0); step();
    check("R2 cand id", idOf(0), 42);
    check("R2 cand req", int'(irqReq[0]), 1);
    check("R11 other cpu untouched id", idOf(1), 1023);
    check("R11 other cpu untouched req", int'(irqReq[1]), 0);
  endtask

  task automatic t_priority();
    clearAll(); setCand(33, 0); setPrio(33, 0, 8'h80);
    setCand(50, 0); setPrio(50, 0, 8'h20); step();
    check("R3 most urgent wins", idOf(0), 50);
  endtask

  task automatic t_tie();
    clearAll(); setCand(35, 0); setCand(60, 0);
    setPrio(35, 0, 8'h40); setPrio(60, 0, 8'h40); step();
    check("R4 tie lower id shared", idOf(0), 35);
    clearAll(); setCand(5, 0); setCand(60, 0);
    setPrio(5, 0, 8'h40); setPrio(60, 0, 8'h40); step();
    check("R4 tie across ranges", idOf(0), 5);
  endtask

  task automatic t_mask();
    clearAll(); setCand(40, 0); setPrio(40, 0, 8'h90);
    prioMask[7:0] = 8'h90; step();
    check("R5 equal to mask published", idOf(0), 40);
    prioMask[7:0] = 8'h8F; step();
    check("R5 above mask id", idOf(0), 1023);
    check("R5 above mask req", int'(irqReq[0]), 0);
  endtask

  task automatic t_running();
    clearAll(); setCand(40, 0); setPrio(40, 0, 8'h50);
    runPrio[8:0] = 9'h050; step();
    check("R6 equal run id", idOf(0), 40);
    check("R6 equal run no req", int'(irqReq[0]), 0);
    runPrio[8:0] = 9'h051; step();
    check("R6 pre-empts req", int'(irqReq[0]), 1);
  endtask

  task automatic t_gates();
    clearAll(); setCand(40, 0); setCand(40, 1);
    globalEn = 1'b0; step();
    check("R7 global off id0", idOf(0), 1023);
    check("R7 global off req", int'(irqReq), 0);
    globalEn = 1'b1; cpuEn = 2'b01; step();
    check("R7 cpu1 off id", idOf(1), 1023);
    check("R7 cpu1 off req", int'(irqReq[1]), 0);
    check("R7 cpu0 still on", idOf(0), 40);
  endtask

  task automatic t_banked();
    clearAll(); setCand(3, 0); setCand(3, 1); setCand(36, 0); setCand(36, 1);
    setPrio(36, 0, 8'h60); setPrio(3, 0, 8'h30); setPrio(3, 1, 8'h90); step();
    check("R8 banked cpu0", idOf(0), 3);
    check("R8 banked cpu1", idOf(1), 36);
  endtask

  task automatic t_latency();
    clearAll(); step();
    setCand(45, 1);
    #1;
    check("R9 no change before edge", idOf(1), 1023);
    @(posedge clk); #1;
    check("R9 change after edge", idOf(1), 45);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    clearAll();
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_candidates();
    t_priority();
    t_tie();
    t_mask();
    t_running();
    t_gates();
    t_banked();
    t_latency();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule